// File: doc/BRIEF.md
# Sleep-Mode Regulator Voltage Controller

This block selects the voltage code driven to the core regulator in run, sleep and deep-sleep modes. Software programs a sleep-mode level and a deep-sleep level through a small register write/read bus. The block then applies the level that matches the current power-mode input. Run mode always uses the nominal 1.2 V code.

Every level request is validated before it is stored. A request is refused when it falls outside the calibrated bounds, when it is low while the clock set up for that mode is too fast, or when it is low while any high-speed interface is active. A refused request leaves the stored level unchanged and sets a sticky error bit for each failing cause. When a debug probe is attached, the low-power levels are bypassed and the run-mode level is applied in every mode.

Top module: `sleep_vreg_ctrl`

## Requirements
- R1: After reset, the sleep level reads as the 1.2 V code (120) and the deep-sleep level as the 0.9 V code (90). The adjust-enable bit and all status flags read 0, and the regulator output is the 1.2 V code.
- R2: A write to the deep-sleep register (offset 1: bits [7:0] level, bit 8 adjust-enable) stores a new level only when bit 8 of the written data is 1. A write with bit 8 equal to 0 clears adjust-enable, leaves the stored level as it is, and makes deep-sleep use the 0.9 V code.
- R3: A requested level below the calibrated minimum (85) or above the calibrated maximum (130) is refused: the stored level is kept and status bit 0 is set. Both bounds themselves are accepted.
- R4: A level below the 1.2 V code is refused when the clock frequency for the target mode is above 30 MHz. Any level is refused when that frequency is above 120 MHz. A refusal for either reason sets status bit 1. The sleep register is checked against the sleep clock input and the deep-sleep register against the deep-sleep clock input.
- R5: A level below the 1.2 V code is refused while any bit of the high-speed interface input is 1, and status bit 2 is set.
- R6: While the debug-attached input is 1, the regulator output is the 1.2 V code in every power mode, from the first clock after it rises.
- R7: The regulator output is registered. One clock after the mode input changes it shows: the 1.2 V code for run (mode 0), the sleep level for sleep (mode 1), and the effective deep-sleep level for deep-sleep (mode 2). An accepted write reaches the output one clock after the register updates.
- R8: The status flags (offset 2, bits [2:0]) stay set until a write to offset 2 with a 1 in that bit position clears them.
- R9: Offset 0 reads the sleep level in bits [7:0]. Offset 3 reads the calibration bounds, minimum in [7:0] and maximum in [15:8], and ignores writes. Writes to offsets 4 to 7 change nothing, and reads from those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write offset |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read offset |
| rd_data_o | output | 16 | Read data (combinational) |
| pmode_i | input | 2 | Power mode: 0 run, 1 sleep, 2 deep-sleep |
| dbg_attached_i | input | 1 | Debug probe attached |
| slp_mhz_i | input | 8 | Clock frequency configured for sleep, in MHz |
| dsl_mhz_i | input | 8 | Clock frequency configured for deep-sleep, in MHz |
| hs_if_active_i | input | 4 | One bit per active high-speed interface |
| vreg_code_o | output | 8 | Voltage code to the regulator |
| err_flags_o | output | 3 | Sticky status: range, clock, interface |

## Verification
The assertions assume that the clock-frequency and interface inputs are stable around the write strobe that they qualify. They also assume that the mode input only takes the codes 0, 1 and 2. The stimulus meets both assumptions: the bench changes these inputs only on falling edges, always before it issues the write, and it never drives mode code 3. The write data and offsets are free. The bench deliberately sends out-of-range levels, writes that have no adjust-enable bit, and writes to undefined offsets.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ERR_W   = 3;
  localparam int unsigned ADJ_BIT = 8;

  localparam logic [ADDR_W-1:0] OFF_SLP  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_DSL  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CAL  = 3'd3;

  localparam int unsigned ERR_RANGE = 0;
  localparam int unsigned ERR_CLK   = 1;
  localparam int unsigned ERR_IF    = 2;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2
  } pmode_e;
endpackage

// File: rtl/svr_req_check.sv
module svr_req_check
  import svr_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned MHZ_W     = 8,
  parameter int unsigned NUM_IF    = 4,
  parameter int unsigned V12_CODE  = 120,
  parameter int unsigned CAL_MIN   = 85,
  parameter int unsigned CAL_MAX   = 130,
  parameter int unsigned LOWV_MHZ  = 30,
  parameter int unsigned HIGHV_MHZ = 120
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MHZ_W-1:0]  mhz_i,
  input  logic [NUM_IF-1:0] hs_if_i,
  output logic [ERR_W-1:0]  bad_o
);
  localparam logic [CODE_W-1:0] LV_V12 = CODE_W'(V12_CODE);
  localparam logic [CODE_W-1:0] LV_MIN = CODE_W'(CAL_MIN);
  localparam logic [CODE_W-1:0] LV_MAX = CODE_W'(CAL_MAX);
  localparam logic [MHZ_W-1:0]  LO_LIM = MHZ_W'(LOWV_MHZ);
  localparam logic [MHZ_W-1:0]  HI_LIM = MHZ_W'(HIGHV_MHZ);

  logic below_nom;

  always_comb begin
    below_nom         = (code_i < LV_V12);
    bad_o             = '0;
    bad_o[ERR_RANGE]  = (code_i < LV_MIN) || (code_i > LV_MAX);
    bad_o[ERR_CLK]    = (below_nom && (mhz_i > LO_LIM)) || (mhz_i > HI_LIM);
    bad_o[ERR_IF]     = below_nom && (|hs_if_i);
  end
endmodule

// File: rtl/svr_regfile.sv
module svr_regfile
  import svr_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned MHZ_W     = 8,
  parameter int unsigned NUM_IF    = 4,
  parameter int unsigned V12_CODE  = 120,
  parameter int unsigned V09_CODE  = 90,
  parameter int unsigned CAL_MIN   = 85,
  parameter int unsigned CAL_MAX   = 130,
  parameter int unsigned LOWV_MHZ  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ERR_W-1:0]  bad_i,
  input  logic [MHZ_W-1:0]  req_mhz_i,
  input  logic [NUM_IF-1:0] hs_if_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CODE_W-1:0] slp_code_o,
  output logic [CODE_W-1:0] dsl_eff_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam logic [CODE_W-1:0] LV_V12 = CODE_W'(V12_CODE);
  localparam logic [CODE_W-1:0] LV_V09 = CODE_W'(V09_CODE);
  localparam logic [CODE_W-1:0] LV_MIN = CODE_W'(CAL_MIN);
  localparam logic [CODE_W-1:0] LV_MAX = CODE_W'(CAL_MAX);
  localparam logic [MHZ_W-1:0]  LO_LIM = MHZ_W'(LOWV_MHZ);

  logic [CODE_W-1:0] slp_q, dsl_q, dsl_d;
  logic              adj_q, adj_d;
  logic [ERR_W-1:0]  flg_q, flg_d;
  logic              slp_en, dsl_en, flg_en;
  logic              wr_slp, wr_dsl, wr_stat, req_ok;
  logic [CODE_W-1:0] req_code;

  // next-state and enables
  always_comb begin
    req_code = wr_data_i[CODE_W-1:0];
    req_ok   = ~|bad_i;
    wr_slp   = wr_en_i && (wr_addr_i == OFF_SLP);
    wr_dsl   = wr_en_i && (wr_addr_i == OFF_DSL);
    wr_stat  = wr_en_i && (wr_addr_i == OFF_STAT);

    slp_en = wr_slp && req_ok;
    dsl_en = 1'b0;
    dsl_d  = dsl_q;
    adj_d  = adj_q;
    if (wr_dsl) begin
      if (wr_data_i[ADJ_BIT]) begin
        if (req_ok) begin
          dsl_en = 1'b1;
          dsl_d  = req_code;
          adj_d  = 1'b1;
        end
      end else begin
        dsl_en = 1'b1;
        adj_d  = 1'b0;
      end
    end

    flg_d  = flg_q;
    flg_en = 1'b0;
    if (wr_stat) begin
      flg_en = 1'b1;
      flg_d  = flg_q & ~wr_data_i[ERR_W-1:0];
    end else if ((wr_slp || (wr_dsl && wr_data_i[ADJ_BIT])) && !req_ok) begin
      flg_en = 1'b1;
      flg_d  = flg_q | bad_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slp_q <= LV_V12;
    end else if (slp_en) begin
      slp_q <= req_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsl_q <= LV_V09;
      adj_q <= 1'b0;
    end else if (dsl_en) begin
      dsl_q <= dsl_d;
      adj_q <= adj_d;
    end
  end

  for (genvar i = 0; i < int'(ERR_W); i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flg_q[i] <= 1'b0;
      end else if (flg_en) begin
        flg_q[i] <= flg_d[i];
      end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_q[i] && !(wr_stat && wr_data_i[i])) |=> flg_q[i]); // R8
  end

  // read mux
  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFF_SLP:  rd_data_o[CODE_W-1:0] = slp_q;
      OFF_DSL: begin
        rd_data_o[CODE_W-1:0] = dsl_q;
        rd_data_o[ADJ_BIT]    = adj_q;
      end
      OFF_STAT: rd_data_o[ERR_W-1:0] = flg_q;
      OFF_CAL: begin
        rd_data_o[CODE_W-1:0]        = LV_MIN;
        rd_data_o[2*CODE_W-1:CODE_W] = LV_MAX;
      end
      default:  rd_data_o = '0;
    endcase
  end

  assign slp_code_o = slp_q;
  assign dsl_eff_o  = adj_q ? dsl_q : LV_V09;
  assign err_o      = flg_q;

  AST_SLP_IN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slp_q >= LV_MIN) && (slp_q <= LV_MAX)); // R3
  AST_REFUSED_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_slp && (|bad_i)) |=> (slp_q == $past(slp_q))); // R3
  AST_LOWV_SLOW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slp_q != $past(slp_q)) && (slp_q < LV_V12)) |-> ($past(req_mhz_i) <= LO_LIM)); // R4
  AST_LOWV_NO_IF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slp_q != $past(slp_q)) && (slp_q < LV_V12)) |-> ($past(hs_if_i) == '0)); // R5
  AST_DSL_NEEDS_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsl_q != $past(dsl_q)) |-> $past(wr_dsl && wr_data_i[ADJ_BIT])); // R2
endmodule

// File: rtl/svr_level_sel.sv
module svr_level_sel
  import svr_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned V12_CODE = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pmode_i,
  input  logic              dbg_i,
  input  logic [CODE_W-1:0] slp_code_i,
  input  logic [CODE_W-1:0] dsl_code_i,
  output logic [CODE_W-1:0] vreg_o
);
  localparam logic [CODE_W-1:0] LV_V12 = CODE_W'(V12_CODE);

  pmode_e            mode;
  logic [CODE_W-1:0] lvl_d, lvl_q;
  logic              lvl_en;

  always_comb begin
    mode = pmode_e'(pmode_i);
    if (dbg_i) begin
      lvl_d = LV_V12;
    end else begin
      case (mode)
        PM_SLEEP: lvl_d = slp_code_i;
        PM_DEEP:  lvl_d = dsl_code_i;
        default:  lvl_d = LV_V12;
      endcase
    end
    lvl_en = (lvl_d != lvl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LV_V12;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign vreg_o = lvl_q;

  AST_DBG_RUN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |=> (vreg_o == LV_V12)); // R6
  AST_WAKE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmode_i == PM_RUN) |=> (vreg_o == LV_V12)); // R7
  AST_SLEEP_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_i && (pmode_i == PM_SLEEP)) |=> (vreg_o == $past(slp_code_i))); // R7
endmodule

// File: rtl/sleep_vreg_ctrl.sv
module sleep_vreg_ctrl
  import svr_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned MHZ_W     = 8,
  parameter int unsigned NUM_IF    = 4,
  parameter int unsigned V12_CODE  = 120,
  parameter int unsigned V09_CODE  = 90,
  parameter int unsigned CAL_MIN   = 85,
  parameter int unsigned CAL_MAX   = 130,
  parameter int unsigned LOWV_MHZ  = 30,
  parameter int unsigned HIGHV_MHZ = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [15:0]       rd_data_o,
  input  logic [1:0]        pmode_i,
  input  logic              dbg_attached_i,
  input  logic [MHZ_W-1:0]  slp_mhz_i,
  input  logic [MHZ_W-1:0]  dsl_mhz_i,
  input  logic [NUM_IF-1:0] hs_if_active_i,
  output logic [CODE_W-1:0] vreg_code_o,
  output logic [2:0]        err_flags_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [MHZ_W-1:0]  req_mhz;
  logic [ERR_W-1:0]  bad;
  logic [CODE_W-1:0] slp_code, dsl_eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign req_mhz = (wr_addr_i == OFF_DSL) ? dsl_mhz_i : slp_mhz_i;

  svr_req_check #(
    .CODE_W(CODE_W), .MHZ_W(MHZ_W), .NUM_IF(NUM_IF), .V12_CODE(V12_CODE),
    .CAL_MIN(CAL_MIN), .CAL_MAX(CAL_MAX), .LOWV_MHZ(LOWV_MHZ), .HIGHV_MHZ(HIGHV_MHZ)
  ) u_check (
    .code_i  (wr_data_i[CODE_W-1:0]),
    .mhz_i   (req_mhz),
    .hs_if_i (hs_if_active_i),
    .bad_o   (bad)
  );

  svr_regfile #(
    .CODE_W(CODE_W), .MHZ_W(MHZ_W), .NUM_IF(NUM_IF), .V12_CODE(V12_CODE),
    .V09_CODE(V09_CODE), .CAL_MIN(CAL_MIN), .CAL_MAX(CAL_MAX), .LOWV_MHZ(LOWV_MHZ)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .bad_i      (bad),
    .req_mhz_i  (req_mhz),
    .hs_if_i    (hs_if_active_i),
    .rd_data_o  (rd_data_o),
    .slp_code_o (slp_code),
    .dsl_eff_o  (dsl_eff),
    .err_o      (err_flags_o)
  );

  svr_level_sel #(
    .CODE_W(CODE_W), .V12_CODE(V12_CODE)
  ) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .pmode_i    (pmode_i),
    .dbg_i      (dbg_attached_i),
    .slp_code_i (slp_code),
    .dsl_code_i (dsl_eff),
    .vreg_o     (vreg_code_o)
  );
endmodule

// File: tb/sleep_vreg_ctrl_bench.sv
module sleep_vreg_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [1:0]  pmode;
  logic        dbg;
  logic [7:0]  slp_mhz, dsl_mhz;
  logic [3:0]  hs;
  logic [7:0]  vreg;
  logic [2:0]  err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_vreg_ctrl u_sleep_vreg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pmode_i(pmode), .dbg_attached_i(dbg), .slp_mhz_i(slp_mhz),
    .dsl_mhz_i(dsl_mhz), .hs_if_active_i(hs), .vreg_code_o(vreg),
    .err_flags_o(err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic out_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk(tag, {8'h00, vreg}, {8'h00, exp});
  endtask

  task automatic t_reset();
    rd_chk("R1 sleep reset", 3'd0, 16'd120);
    rd_chk("R1 deep reset", 3'd1, 16'd90);
    rd_chk("R1 status reset", 3'd2, 16'd0);
    chk("R1 output reset", {8'h00, vreg}, 16'd120);
  endtask

  task automatic t_sleep_level();
    wr(3'd0, 16'd100);
    rd_chk("R7 sleep stored", 3'd0, 16'd100);
    pmode = 2'd1;
    out_chk("R7 sleep level", 8'd100);
    wr(3'd0, 16'd110);
    out_chk("R7 write reaches output", 8'd110);
    pmode = 2'd0;
    out_chk("R7 wake to run", 8'd120);
    rd_chk("R7 no error", 3'd2, 16'd0);
  endtask

  task automatic t_range();
    wr(3'd0, 16'd84);
    rd_chk("R3 below min kept", 3'd0, 16'd110);
    rd_chk("R3 range flag", 3'd2, 16'd1);
    wr(3'd0, 16'd131);
    rd_chk("R3 above max kept", 3'd0, 16'd110);
    wr(3'd0, 16'd130);
    rd_chk("R3 max accepted", 3'd0, 16'd130);
    rd_chk("R8 flag sticky", 3'd2, 16'd1);
    wr(3'd0, 16'd85);
    rd_chk("R3 min accepted", 3'd0, 16'd85);
    wr(3'd2, 16'd1);
    rd_chk("R8 w1c clears", 3'd2, 16'd0);
    wr(3'd0, 16'd100);
  endtask

  task automatic t_clock();
    slp_mhz = 8'd48;
    wr(3'd0, 16'd95);
    rd_chk("R4 fast clock low level kept", 3'd0, 16'd100);
    rd_chk("R4 clock flag", 3'd2, 16'd2);
    wr(3'd2, 16'd1);
    rd_chk("R8 other bit clear no effect", 3'd2, 16'd2);
    wr(3'd0, 16'd125);
    rd_chk("R4 nominal at 48MHz ok", 3'd0, 16'd125);
    slp_mhz = 8'd30;
    wr(3'd0, 16'd90);
    rd_chk("R4 30MHz boundary ok", 3'd0, 16'd90);
    slp_mhz = 8'd121;
    wr(3'd0, 16'd120);
    rd_chk("R4 over 120MHz kept", 3'd0, 16'd90);
    wr(3'd2, 16'd7);
    rd_chk("R8 clear all", 3'd2, 16'd0);
    slp_mhz = 8'd16;
  endtask

  task automatic t_intf();
    hs = 4'b1000;
    wr(3'd0, 16'd110);
    rd_chk("R5 low level with iface kept", 3'd0, 16'd90);
    rd_chk("R5 iface flag", 3'd2, 16'd4);
    chk("R5 flag port", {13'd0, err}, 16'd4);
    wr(3'd0, 16'd120);
    rd_chk("R5 nominal with iface ok", 3'd0, 16'd120);
    wr(3'd2, 16'd4);
    hs = 4'b0000;
  endtask

  task automatic t_deep();
    pmode = 2'd2;
    out_chk("R2 default deep level", 8'd90);
    wr(3'd1, 16'd110);
    rd_chk("R2 no adjust keeps level", 3'd1, 16'd90);
    out_chk("R2 no adjust output", 8'd90);
    wr(3'd1, 16'h0100 | 16'd110);
    rd_chk("R2 adjust stores", 3'd1, 16'h016E);
    out_chk("R2 adjust output", 8'd110);
    dsl_mhz = 8'd48;
    wr(3'd1, 16'h0100 | 16'd100);
    rd_chk("R4 deep clock refused", 3'd1, 16'h016E);
    rd_chk("R4 deep clock flag", 3'd2, 16'd2);
    wr(3'd2, 16'd2);
    dsl_mhz = 8'd16;
    wr(3'd1, 16'h0000);
    rd_chk("R2 adjust cleared", 3'd1, 16'h006E);
    out_chk("R2 back to default", 8'd90);
  endtask

  task automatic t_dbg();
    wr(3'd0, 16'd100);
    dbg = 1'b1;
    out_chk("R6 debug in deep", 8'd120);
    pmode = 2'd1;
    out_chk("R6 debug in sleep", 8'd120);
    dbg = 1'b0;
    out_chk("R6 release", 8'd100);
    pmode = 2'd0;
    out_chk("R7 run", 8'd120);
  endtask

  task automatic t_map();
    wr(3'd5, 16'h00FF);
    rd_chk("R9 sleep unchanged", 3'd0, 16'd100);
    rd_chk("R9 deep unchanged", 3'd1, 16'h006E);
    rd_chk("R9 status unchanged", 3'd2, 16'd0);
    rd_chk("R9 undefined reads zero", 3'd5, 16'd0);
    wr(3'd3, 16'd0);
    rd_chk("R9 calibration read-only", 3'd3, 16'h8255);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    pmode = 2'd0; dbg = 1'b0; slp_mhz = 8'd16; dsl_mhz = 8'd16; hs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sleep_level();
    t_range();
    t_clock();
    t_intf();
    t_deep();
    t_dbg();
    t_map();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule